// File: doc/BRIEF.md
# Mono I2S Master Receiver

This block drives an I2S link as the bus master toward one digital microphone. A parameterised divider derives the bit clock from the system clock. A frame sequencer produces a word-select signal that stays low for one 32-bit slot and high for the next. Together the two slots form a 64-bit-clock frame. With a 2 MHz bit clock this gives a 31.25 kHz sample rate.

Only the slot in which word-select is low is captured, so the output is mono. That slot has a one-bit delay after the word-select edge. The next 24 bits are shifted in MSB first and kept as a signed two's-complement sample. The trailing bits of the slot and the whole high slot are discarded. Each new sample appears on `sample_o` together with a strobe that lasts one system clock. The value then holds until the next strobe.

A microphone whose resolution is below 24 bits also works. It drives zeros in the unused low-order positions, and these land in the least significant bits of the sample.

Top module: `i2s_mono_master_rx`

## Requirements
- R1: `bclk_o` is low after reset. It then toggles once every HALF_DIV system clocks, so one bit-clock period spans 2*HALF_DIV system clocks.
- R2: `ws_o` changes only on the system clock at which `bclk_o` falls. After reset it stays low for 32 bit-clock periods, then high for 32, and this repeats.
- R3: Within the low slot, the first rising edge of the bit clock (slot bit 0) carries no sample data. Slot bits 1 to 24 are sampled on rising edges of `bclk_o` and form the sample MSB first: slot bit 1 becomes sample bit 23.
- R4: Data arriving on `sd_i` while `ws_o` is high has no effect on `sample_o` or `sample_valid_o`.
- R5: Slot bits 25 to 31 of the low slot are discarded and never change `sample_o`.
- R6: `sample_valid_o` is high for exactly one system clock. It rises on the clock at which `bclk_o` rises for slot bit 24 of the low slot, and `sample_o` carries the new sample in that same clock. `sample_o` holds its value between strobes.
- R7: Samples are 24-bit two's complement. The extreme codes 0x800000 and 0x7FFFFF, as well as 0x000000 and 0xFFFFFF, come through unchanged.
- R8: A synchronous active-high `rst` forces `bclk_o` and `ws_o` low, clears `sample_valid_o`, clears `sample_o` and the shift register, and restarts the frame at slot bit 0. A partially shifted sample is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_i | input | 1 | Serial data from the microphone |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Generated word-select: low selects the captured slot |
| sample_o | output | SAMPLE_W | Last captured signed sample |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume that `sd_i` changes only after a falling bit-clock edge and stays stable over the following rising edge, as an I2S slave does. They also assume `rst` is a clean synchronous level. The bench acts as the microphone. From its own cycle count it derives the current slot position and updates `sd_i` on falling system-clock edges, only within the bit period that follows a falling bit-clock edge. The delay bit, the tail bits and the high slot carry bit patterns inverted from the real sample, so that any capture at the wrong position shows up. A second reset is applied in the middle of a low slot to confirm that the partially shifted sample is dropped.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    parameter int unsigned DEF_SLOT_BITS = 32;
    parameter int unsigned DEF_SAMPLE_W  = 24;
    parameter int unsigned DEF_HALF_DIV  = 25;

    typedef enum logic {
        SLOT_CAPTURE = 1'b0,
        SLOT_SKIP    = 1'b1
    } slot_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_evt_t;

    function automatic logic in_data_window(input int unsigned pos, input int unsigned width);
        return (pos >= 1) && (pos <= width);
    endfunction

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div
    import i2s_rx_pkg::*;
#(
    parameter int unsigned HALF_DIV = DEF_HALF_DIV
) (
    input  logic      clk,
    input  logic      rst,
    output logic      bclk_o,
    output bclk_evt_t evt_o
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            bclk_o <= ~bclk_o;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        evt_o.rise = tick & ~bclk_o;
        evt_o.fall = tick &  bclk_o;
    end

    // R1: the bit clock only moves after a full divider count
    p_bclk_tick_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(bclk_o) |-> ($past(cnt) == CW'(HALF_DIV - 1)));

endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
    import i2s_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  bclk_evt_t                    evt_i,
    output slot_e                        slot_o,
    output logic [$clog2(SLOT_BITS)-1:0] pos_o
);
    localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;
    localparam int unsigned FW         = $clog2(FRAME_BITS);
    localparam int unsigned PW         = $clog2(SLOT_BITS);

    logic [FW-1:0] idx;
    logic [FW-1:0] idx_nxt;

    assign idx_nxt = (idx == FW'(FRAME_BITS - 1)) ? '0 : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            slot_o <= SLOT_CAPTURE;
        end else if (evt_i.fall) begin
            idx    <= idx_nxt;
            slot_o <= (idx_nxt >= FW'(SLOT_BITS)) ? SLOT_SKIP : SLOT_CAPTURE;
        end
    end

    assign pos_o = (idx >= FW'(SLOT_BITS)) ? PW'(idx - FW'(SLOT_BITS)) : PW'(idx);

    // R2: word-select moves only with a falling bit clock
    p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(slot_o) |-> $past(evt_i.fall));

    // R2: slot position advances only with a falling bit clock
    p_pos_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx) |-> $past(evt_i.fall));

endmodule

// File: rtl/i2s_slot_capture.sv
module i2s_slot_capture
    import i2s_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  bclk_evt_t                    evt_i,
    input  slot_e                        slot_i,
    input  logic [$clog2(SLOT_BITS)-1:0] pos_i,
    input  logic                         sd_i,
    output logic [SAMPLE_W-1:0]          sample_o,
    output logic                         valid_o
);
    localparam int unsigned PW = $clog2(SLOT_BITS);

    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] shifted;
    logic                take;
    logic                last;

    assign shifted = {shreg[SAMPLE_W-2:0], sd_i};
    assign take    = evt_i.rise && (slot_i == SLOT_CAPTURE) && in_data_window(32'(pos_i), SAMPLE_W);
    assign last    = (pos_i == PW'(SAMPLE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (take) begin
                shreg <= shifted;
                if (last) begin
                    sample_o <= shifted;
                    valid_o  <= 1'b1;
                end
            end
        end
    end

    // R6: strobe lasts a single system clock
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: output holds between strobes
    p_sample_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(sample_o));

    // R4: no sample is produced from the skipped slot
    p_valid_slot_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (slot_i == SLOT_CAPTURE));

endmodule

// File: rtl/i2s_mono_master_rx.sv
module i2s_mono_master_rx
    import i2s_rx_pkg::*;
#(
    parameter int unsigned HALF_DIV  = DEF_HALF_DIV,
    parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sd_i,
    output logic                bclk_o,
    output logic                ws_o,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o
);
    localparam int unsigned PW = $clog2(SLOT_BITS);

    bclk_evt_t     evt;
    slot_e         slot;
    logic [PW-1:0] pos;

    i2s_bclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .bclk_o (bclk_o),
        .evt_o  (evt)
    );

    i2s_frame_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .slot_o (slot),
        .pos_o  (pos)
    );

    i2s_slot_capture #(.SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .slot_i   (slot),
        .pos_i    (pos),
        .sd_i     (sd_i),
        .sample_o (sample_o),
        .valid_o  (sample_valid_o)
    );

    assign ws_o = (slot == SLOT_SKIP);

    // R3: a sample is completed only on a rising bit clock
    p_valid_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |-> $rose(bclk_o));

    // R8: reset drives the link outputs low
    p_reset_state_r8: assert property (@(posedge clk)
        $past(rst) |-> (!bclk_o && !ws_o && !sample_valid_o));

endmodule

// File: tb/tb_i2s_mono_master_rx.sv
module tb_i2s_mono_master_rx;

    localparam int HD    = 3;
    localparam int FRAME = 64 * 2 * HD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd  = 1'b0;
    logic        bclk, ws, valid;
    logic [23:0] sample;

    int n_cmp  = 0;
    int n_bad  = 0;
    int k      = 0;
    int cyc    = 0;
    bit started = 1'b0;
    logic [23:0] exp_sample = '0;

    always #4 clk = ~clk;

    i2s_mono_master_rx #(.HALF_DIV(HD), .SLOT_BITS(32), .SAMPLE_W(24)) dut (
        .clk            (clk),
        .rst            (rst),
        .sd_i           (sd),
        .bclk_o         (bclk),
        .ws_o           (ws),
        .sample_o       (sample),
        .sample_valid_o (valid)
    );

    function automatic logic [23:0] word_of(input int f);
        logic [23:0] base;
        case (f % 8)
            0: base = 24'h800000;
            1: base = 24'h7FFFFF;
            2: base = 24'h000000;
            3: base = 24'hFFFFFF;
            4: base = 24'hA5A5A5;
            5: base = 24'h5A5A5A;
            6: base = 24'h123456;
            default: base = 24'hEDCBA9;
        endcase
        return base ^ (24'(f / 8) * 24'h010203);
    endfunction

    // microphone: slot bits 1..24 carry the word, everything else carries inverted junk
    function automatic logic mic_bit(input int f, input int p);
        logic [23:0] w;
        w = word_of(f);
        if (p >= 1 && p <= 24) return w[24 - p];
        if (p == 0)            return ~w[23];
        if (p < 32)            return ~w[0];
        return ~w[p % 24];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at k=%0d: actual %h expected %h", req, k, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        started <= 1'b1;
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    always @(negedge clk) begin
        if (started) begin
            int t, g, tr;
            logic e_bclk, e_ws, e_valid;
            t       = k / HD;
            g       = t / 2;
            e_bclk  = logic'(t % 2);
            e_ws    = ((g % 64) >= 32);
            tr      = (t - 1) / 2;
            e_valid = (k > 0) && (k % HD == 0) && (t % 2 == 1) && ((tr % 64) == 24);
            if (k == 0) begin
                exp_sample = '0;
                chk("R8 reset bclk", {31'd0, bclk}, 32'd0);
                chk("R8 reset ws", {31'd0, ws}, 32'd0);
                chk("R8 reset valid", {31'd0, valid}, 32'd0);
                chk("R8 reset sample", {8'd0, sample}, 32'd0);
            end else begin
                if (e_valid) exp_sample = word_of(tr / 64);
                chk("R1 bclk", {31'd0, bclk}, {31'd0, e_bclk});
                chk("R2 ws", {31'd0, ws}, {31'd0, e_ws});
                chk("R6 valid", {31'd0, valid}, {31'd0, e_valid});
                chk("R3 R4 R5 R7 sample", {8'd0, sample}, {8'd0, exp_sample});
            end
            sd <= mic_bit(g / 64, g % 64);
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 200000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 200000", cyc);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // nine frames: extremes (R7), ordering (R3), skipped slot (R4), tail bits (R5)
        repeat (9 * FRAME + 37) @(negedge clk);
        // R8: reset in the middle of a captured slot
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3 * FRAME + 20) @(negedge clk);
        finish_run();
    end

endmodule